// File: doc/BRIEF.md
# Registered bidirectional bus transceiver

This block joins two equal-width buses, port A and port B, through a pair of storage registers. Each register belongs to one direction and has its own clock. The A-to-B register takes the word on port A at every rising edge of its clock. The B-to-A register takes the word on port B at every rising edge of its own clock. The output enable and the direction select have no effect on these loads.

An active-low enable and a direction select decide which port is driven, if any. The driven port carries one of two words, picked by the select for that direction: the live word on the opposite port, or the word stored in the register for that direction. Each bus is modelled as a separate input, output and output-enable, so no tri-state net is needed inside the block. A wrapper at the pad ring can merge the three signals of each bus into an inout pin. When a port is not driven, its output data is held at zero.

Top module: `dual_port_xcvr`

## Requirements
- R1: A high level on `rst_ab` at a rising edge of `clk_ab` clears the A-to-B register to zero. A high level on `rst_ba` at a rising edge of `clk_ba` clears the B-to-A register to zero. Neither reset touches the other register.
- R2: On every rising edge of `clk_ab` with `rst_ab` low, the A-to-B register loads `a_in`. This happens whatever the values of `oe_n` and `dir_b`.
- R3: On every rising edge of `clk_ba` with `rst_ba` low, the B-to-A register loads `b_in`. This happens whatever the values of `oe_n` and `dir_b`.
- R4: While `oe_n` is 1, `a_oe` and `b_oe` are both 0 and `a_out` and `b_out` are both zero.
- R5: While `oe_n` is 0 and `dir_b` is 0, `a_oe` is 1 and `b_oe` is 0. With `use_ba_reg` at 0, `a_out` equals `b_in`.
- R6: While `oe_n` is 0, `dir_b` is 0 and `use_ba_reg` is 1, `a_out` equals the B-to-A register.
- R7: While `oe_n` is 0 and `dir_b` is 1, `b_oe` is 1 and `a_oe` is 0. With `use_ab_reg` at 0, `b_out` equals `a_in`.
- R8: While `oe_n` is 0, `dir_b` is 1 and `use_ab_reg` is 1, `b_out` equals the A-to-B register.
- R9: `a_oe` and `b_oe` are never both 1.
- R10: A register keeps its word for as long as its own clock has no rising edge. Edges of the other clock leave it unchanged.
- R11: The outputs are combinational in the control inputs, the port inputs and the register contents. A change on an input shows on the outputs with no clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Clock of the A-to-B register |
| rst_ab | input | 1 | Synchronous active-high clear, A-to-B register |
| clk_ba | input | 1 | Clock of the B-to-A register |
| rst_ba | input | 1 | Synchronous active-high clear, B-to-A register |
| oe_n | input | 1 | Active-low output enable |
| dir_b | input | 1 | 1: drive port B, 0: drive port A |
| use_ab_reg | input | 1 | 1: port B shows the stored A word, 0: live `a_in` |
| use_ba_reg | input | 1 | 1: port A shows the stored B word, 0: live `b_in` |
| a_in | input | WIDTH | Word present on port A |
| a_out | output | WIDTH | Word driven onto port A |
| a_oe | output | 1 | Port A driver enable |
| b_in | input | WIDTH | Word present on port B |
| b_out | output | WIDTH | Word driven onto port B |
| b_oe | output | 1 | Port B driver enable |

## Verification
The bench builds the block with WIDTH set to 4. This makes the full 16-value range on each port small enough to sweep. Every data value is driven through both live paths and both stored paths, so a stuck or swapped lane in the generate loop shows up. The bench drives each clock by hand, which lets it give one register an edge while the other gets none, and clear one register while the other is kept. Captures are checked only while the capturing port is an input, because the word stored from a port that is being driven is not defined.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

  typedef enum logic [1:0] {
    DRV_NONE = 2'b00,
    DRV_A    = 2'b01,
    DRV_B    = 2'b10
  } drive_e;

  function automatic drive_e decode_drive(input logic oe_n, input logic dir_b);
    if (oe_n) return DRV_NONE;
    return dir_b ? DRV_B : DRV_A;
  endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end

endmodule

// File: rtl/xcvr_ctl.sv
module xcvr_ctl
  import xcvr_pkg::*;
(
  input  logic oe_n,
  input  logic dir_b,
  output logic drv_a,
  output logic drv_b
);

  drive_e mode;

  always_comb begin
    mode  = decode_drive(oe_n, dir_b);
    drv_a = (mode == DRV_A);
    drv_b = (mode == DRV_B);
  end

endmodule

// File: rtl/xcvr_lane.sv
module xcvr_lane (
  input  logic a_bit,
  input  logic b_bit,
  input  logic ra_bit,
  input  logic rb_bit,
  input  logic use_ab_reg,
  input  logic use_ba_reg,
  input  logic drv_a,
  input  logic drv_b,
  output logic a_o,
  output logic b_o
);

  logic to_a, to_b;

  always_comb begin
    to_a = use_ba_reg ? rb_bit : b_bit;
    to_b = use_ab_reg ? ra_bit : a_bit;
    a_o  = drv_a & to_a;
    b_o  = drv_b & to_b;
  end

endmodule

// File: rtl/dual_port_xcvr.sv
module dual_port_xcvr #(
  parameter int WIDTH = 8
) (
  input  logic             clk_ab,
  input  logic             rst_ab,
  input  logic             clk_ba,
  input  logic             rst_ba,
  input  logic             oe_n,
  input  logic             dir_b,
  input  logic             use_ab_reg,
  input  logic             use_ba_reg,
  input  logic [WIDTH-1:0] a_in,
  output logic [WIDTH-1:0] a_out,
  output logic             a_oe,
  input  logic [WIDTH-1:0] b_in,
  output logic [WIDTH-1:0] b_out,
  output logic             b_oe
);

  localparam int LANES = WIDTH;

  logic [WIDTH-1:0] ab_word;
  logic [WIDTH-1:0] ba_word;
  logic             drv_a, drv_b;

  xcvr_store #(.WIDTH(WIDTH)) u_store_ab (
    .clk (clk_ab),
    .rst (rst_ab),
    .d   (a_in),
    .q   (ab_word)
  );

  xcvr_store #(.WIDTH(WIDTH)) u_store_ba (
    .clk (clk_ba),
    .rst (rst_ba),
    .d   (b_in),
    .q   (ba_word)
  );

  xcvr_ctl u_ctl (
    .oe_n  (oe_n),
    .dir_b (dir_b),
    .drv_a (drv_a),
    .drv_b (drv_b)
  );

  generate
    for (genvar i = 0; i < LANES; i++) begin : g_lane
      xcvr_lane u_lane (
        .a_bit      (a_in[i]),
        .b_bit      (b_in[i]),
        .ra_bit     (ab_word[i]),
        .rb_bit     (ba_word[i]),
        .use_ab_reg (use_ab_reg),
        .use_ba_reg (use_ba_reg),
        .drv_a      (drv_a),
        .drv_b      (drv_b),
        .a_o        (a_out[i]),
        .b_o        (b_out[i])
      );
    end
  endgenerate

  assign a_oe = drv_a;
  assign b_oe = drv_b;

endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int WIDTH = 8
) (
  input logic             clk_ab,
  input logic             rst_ab,
  input logic             clk_ba,
  input logic             rst_ba,
  input logic             oe_n,
  input logic             dir_b,
  input logic             use_ab_reg,
  input logic             use_ba_reg,
  input logic [WIDTH-1:0] a_in,
  input logic [WIDTH-1:0] a_out,
  input logic             a_oe,
  input logic [WIDTH-1:0] b_in,
  input logic [WIDTH-1:0] b_out,
  input logic             b_oe
);

  AST_ONE_DRIVER: assert property (@(posedge clk_ab) disable iff (rst_ab) !(a_oe && b_oe)); // R9

  AST_ISOLATED: assert property (@(posedge clk_ab) disable iff (rst_ab)
    oe_n |-> (!a_oe && !b_oe && a_out == '0 && b_out == '0)); // R4

  AST_LIVE_TO_B: assert property (@(posedge clk_ab) disable iff (rst_ab)
    (!oe_n && dir_b && !use_ab_reg) |-> (b_oe && b_out == a_in)); // R7

  AST_LIVE_TO_A: assert property (@(posedge clk_ba) disable iff (rst_ba)
    (!oe_n && !dir_b && !use_ba_reg) |-> (a_oe && a_out == b_in)); // R5

  AST_STORED_TO_B: assert property (@(posedge clk_ab) disable iff (rst_ab)
    (!$past(rst_ab) && !$past(!oe_n && !dir_b) && !oe_n && dir_b && use_ab_reg)
      |-> (b_out == $past(a_in))); // R8

  AST_STORED_TO_A: assert property (@(posedge clk_ba) disable iff (rst_ba)
    (!$past(rst_ba) && !$past(!oe_n && dir_b) && !oe_n && !dir_b && use_ba_reg)
      |-> (a_out == $past(b_in))); // R6

  AST_CLEAR_AB: assert property (@(posedge clk_ab) disable iff (rst_ab)
    ($past(rst_ab) && !oe_n && dir_b && use_ab_reg) |-> (b_out == '0)); // R1

  AST_CLEAR_BA: assert property (@(posedge clk_ba) disable iff (rst_ba)
    ($past(rst_ba) && !oe_n && !dir_b && use_ba_reg) |-> (a_out == '0)); // R1

endmodule

bind dual_port_xcvr xcvr_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_ab     (clk_ab),
  .rst_ab     (rst_ab),
  .clk_ba     (clk_ba),
  .rst_ba     (rst_ba),
  .oe_n       (oe_n),
  .dir_b      (dir_b),
  .use_ab_reg (use_ab_reg),
  .use_ba_reg (use_ba_reg),
  .a_in       (a_in),
  .a_out      (a_out),
  .a_oe       (a_oe),
  .b_in       (b_in),
  .b_out      (b_out),
  .b_oe       (b_oe)
);

// File: tb/dual_port_xcvr_tb.sv
module dual_port_xcvr_tb;

  localparam int W    = 4;
  localparam int NVAL = 1 << W;

  logic         clk_ab = 0, rst_ab = 1, clk_ba = 0, rst_ba = 1;
  logic         oe_n = 1, dir_b = 0, use_ab_reg = 0, use_ba_reg = 0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, b_out;
  logic         a_oe, b_oe;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  dual_port_xcvr #(.WIDTH(W)) u_dut (
    .clk_ab(clk_ab), .rst_ab(rst_ab), .clk_ba(clk_ba), .rst_ba(rst_ba),
    .oe_n(oe_n), .dir_b(dir_b), .use_ab_reg(use_ab_reg), .use_ba_reg(use_ba_reg),
    .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  // 50 MHz edges, driven on demand: 10 ns high, 10 ns low
  task automatic tick_ab();
    #10 clk_ab = 1;
    #10 clk_ab = 0;
  endtask

  task automatic tick_ba();
    #10 clk_ba = 1;
    #10 clk_ba = 0;
  endtask

  task automatic expect_val(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic expect_bit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic view_a_reg(input string req, input logic [W-1:0] exp);
    oe_n = 0; dir_b = 1; use_ab_reg = 1; #1;
    expect_val(req, b_out, exp);
  endtask

  task automatic view_b_reg(input string req, input logic [W-1:0] exp);
    oe_n = 0; dir_b = 0; use_ba_reg = 1; #1;
    expect_val(req, a_out, exp);
  endtask

  initial begin
    // R1: clear both registers
    tick_ab(); tick_ba();
    rst_ab = 0; rst_ba = 0;
    a_in = 4'hF; b_in = 4'hF;
    view_a_reg("R1 A reg after reset", '0);
    view_b_reg("R1 B reg after reset", '0);

    // R4/R9: isolation over every control combination and data
    oe_n = 1;
    for (int v = 0; v < NVAL; v++) begin
      for (int c = 0; c < 8; c++) begin
        a_in = W'(v); b_in = W'(~v);
        dir_b = c[0]; use_ab_reg = c[1]; use_ba_reg = c[2]; #1;
        expect_bit("R4 a_oe off", a_oe, 1'b0);
        expect_bit("R4 b_oe off", b_oe, 1'b0);
        expect_val("R4 a_out zero", a_out, '0);
        expect_val("R4 b_out zero", b_out, '0);
      end
    end

    // R5/R7/R9/R11: live paths, no clock edges
    oe_n = 0; use_ab_reg = 0; use_ba_reg = 0;
    for (int v = 0; v < NVAL; v++) begin
      dir_b = 1; a_in = W'(v); b_in = W'(v ^ 5); #1;
      expect_val("R7 live A to B", b_out, W'(v));
      expect_bit("R7 b_oe", b_oe, 1'b1);
      expect_bit("R9 a_oe off", a_oe, 1'b0);
      dir_b = 0; b_in = W'(v); a_in = W'(v ^ 9); #1;
      expect_val("R5 live B to A", a_out, W'(v));
      expect_bit("R5 a_oe", a_oe, 1'b1);
      expect_bit("R9 b_oe off", b_oe, 1'b0);
      b_in = W'(~v); #1;
      expect_val("R11 combinational follow", a_out, W'(~v));
    end

    // R2/R3/R6/R8: store both words in isolation, then show them
    for (int v = 0; v < NVAL; v++) begin
      oe_n = 1; a_in = W'(v); b_in = W'(~v);
      tick_ab(); tick_ba();
      a_in = W'(v ^ 3); b_in = W'(v ^ 12);
      view_a_reg("R8 stored A on B", W'(v));
      view_b_reg("R6 stored B on A", W'(~v));
    end

    // R2: capture while B is driven (A is input)
    oe_n = 0; dir_b = 1; use_ab_reg = 1; a_in = 4'h5;
    tick_ab(); a_in = 4'hA; #1;
    expect_val("R2 capture with output enabled", b_out, 4'h5);
    // R3: capture while A is driven (B is input)
    oe_n = 0; dir_b = 0; use_ba_reg = 1; b_in = 4'h9;
    tick_ba(); b_in = 4'h6; #1;
    expect_val("R3 capture with output enabled", a_out, 4'h9);

    // R10: edges on one clock leave the other register alone
    oe_n = 1; a_in = 4'hE; b_in = 4'h1;
    tick_ab();   // A reg now E
    b_in = 4'h7; tick_ab(); // B reg not clocked: still 9
    view_b_reg("R10 B reg held over clk_ab edges", 4'h9);
    oe_n = 1; a_in = 4'h2; tick_ba(); // A reg not clocked: still E, B reg 2? b_in=7
    view_a_reg("R10 A reg held over clk_ba edge", 4'hE);
    view_b_reg("R3 B reg took b_in", 4'h7);

    // R1: independent reset of the A register only
    oe_n = 1; rst_ab = 1; tick_ab(); rst_ab = 0;
    view_a_reg("R1 A reg cleared alone", '0);
    view_b_reg("R1 B reg kept", 4'h7);
    oe_n = 1; rst_ba = 1; tick_ba(); rst_ba = 0;
    view_b_reg("R1 B reg cleared", '0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2_000_000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule